// File: doc/BRIEF.md
# Power Sequence Command Engine

This block walks a table of packed power-sequence entries, one entry per table index starting at zero, and carries each one out against an 8-bit register bus. An entry can read a register, change selected bits of a register, wait until selected bits of a register reach a target pattern, or pause for a number of microseconds or milliseconds. An end entry closes the sequence. Every entry carries three applicability masks. The engine carries out an entry only when the configured silicon revision, fab and host interface are all enabled in it, and it passes over any other entry.

Software sets the configuration inputs and pulses `start`. The engine raises `busy` while it runs. It finishes with `done` when it reaches an end entry, or with `error` when a poll times out or an entry holds an opcode it does not know. A free-running one-microsecond tick paces the waits. Each read entry hands its masked result out on `rd_data` with a one-cycle `rd_valid` strobe.

Top module: `pwrseq_engine`

## Requirements
- R1: Entry bits are, MSB first: offset [55:40], revision mask [39:32], fab mask [31:28], interface mask [27:24], address space [23:20], opcode [19:16], bit mask [15:8], value [7:0]. An entry executes only if revision-mask bit `cfg_cut`, fab-mask bit `cfg_fab` and interface-mask bit `cfg_intf` are all set. Otherwise the entry is skipped with no bus access.
- R2: Opcode 0 (read) makes one bus read at space/offset. The cycle after the acknowledge, `rd_valid` pulses and `rd_data` holds read data AND bit mask. The value field is not used.
- R3: Opcode 1 (write) reads the register and then writes (old AND NOT mask) OR (value AND mask) to the same space and offset.
- R4: Opcode 2 (poll) reads repeatedly until (data AND mask) equals (value AND mask), and then moves to the next entry.
- R5: A poll that sees POLL_LIMIT (default 20000) non-matching reads stops the sequence with `error`. No further bus access follows.
- R6: Opcode 3 (delay) waits offset ticks of `us_tick` when value bit 0 is 0. It waits offset times 1000 ticks when value bit 0 is 1.
- R7: Opcode 4 (end) stops the sequence with `done` high, `error` low and `busy` low.
- R8: Opcodes 5 to 15 stop the sequence with `error` high and `done` low, with no bus access for that entry.
- R9: After reset the engine is idle with all outputs low. A `start` pulse while idle clears `done`/`error` and runs from entry 0. `start` has no effect while `busy` is high.
- R10: Once `bus_req` is raised, it and `bus_we`, `bus_space`, `bus_addr` and `bus_wdata` stay unchanged until `bus_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence from entry 0 (idle only) |
| cfg_cut | input | 3 | Configured revision index into the revision mask |
| cfg_fab | input | 2 | Configured fab index into the fab mask |
| cfg_intf | input | 2 | Configured interface index (0 SDIO, 1 USB, 2 PCIe) |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last sequence reached an end entry |
| error | output | 1 | Last sequence ended on timeout or bad opcode |
| tbl_addr | output | TBL_AW | Entry table index (combinational read) |
| tbl_data | input | 56 | Entry at `tbl_addr` |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_space | output | 4 | Address space (0 MAC, 1 USB, 2 PCIe, 3 SDIO) |
| bus_addr | output | 16 | Register offset |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Access complete |
| rd_valid | output | 1 | Read-entry result strobe |
| rd_data | output | 8 | Masked read result |

## Verification
Some properties are checked on every cycle. The bus request holds steady until it is acknowledged. No request is raised while the engine is idle. `done` never appears with `busy`. The poll attempt counter stays below its limit. The delay counter never counts upward except on a load. Other behaviour needs the bench's scenarios. These cover the applicability gating and the merge value of a write. They cover a poll that succeeds late and one that runs to exactly the limit of attempts. They also cover the tick counts of microsecond and millisecond waits, the error on an unknown opcode, and a start pulse that has no effect during a wait.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    localparam int ENTRY_W = 56;

    localparam logic [3:0] CMD_READ  = 4'd0;
    localparam logic [3:0] CMD_WRITE = 4'd1;
    localparam logic [3:0] CMD_POLL  = 4'd2;
    localparam logic [3:0] CMD_DELAY = 4'd3;
    localparam logic [3:0] CMD_END   = 4'd4;

    typedef struct packed {
        logic [15:0] offset;
        logic [7:0]  rev_m;
        logic [3:0]  fab_m;
        logic [3:0]  intf_m;
        logic [3:0]  space;
        logic [3:0]  cmd;
        logic [7:0]  bmask;
        logic [7:0]  val;
    } entry_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_RD,
        ST_WR,
        ST_WAIT
    } state_e;

    function automatic logic [7:0] merge_bits(input logic [7:0] old,
                                              input logic [7:0] m,
                                              input logic [7:0] v);
        return (old & ~m) | (v & m);
    endfunction

    function automatic logic masked_eq(input logic [7:0] a,
                                       input logic [7:0] b,
                                       input logic [7:0] m);
        return (a & m) == (b & m);
    endfunction

endpackage

// File: rtl/pwrseq_gate.sv
module pwrseq_gate
    import pwrseq_pkg::*;
(
    input  entry_t     ent,
    input  logic [2:0] cfg_cut,
    input  logic [1:0] cfg_fab,
    input  logic [1:0] cfg_intf,
    output logic       applies
);
    always_comb begin
        applies = ent.rev_m[cfg_cut] & ent.fab_m[cfg_fab] & ent.intf_m[cfg_intf];
    end
endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
    parameter int MS_TICKS = 1000,
    parameter int AMT_W    = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [AMT_W-1:0] amount,
    input  logic             unit_ms,
    input  logic             tick,
    output logic             expired
);
    localparam int DLY_W = AMT_W + $clog2(MS_TICKS);

    logic [DLY_W-1:0] cnt_q;
    logic [DLY_W-1:0] scale;

    always_comb begin
        scale = unit_ms ? DLY_W'(MS_TICKS) : DLY_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= DLY_W'(amount) * scale;
        end else if (tick && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    AST_DLY_NO_RISE: assert property (@(posedge clk) disable iff (rst)
        !load |=> cnt_q <= $past(cnt_q)); // R6

endmodule

// File: rtl/pwrseq_engine.sv
module pwrseq_engine
    import pwrseq_pkg::*;
#(
    parameter int TBL_AW     = 8,
    parameter int POLL_LIMIT = 20000,
    parameter int MS_TICKS   = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        cfg_cut,
    input  logic [1:0]        cfg_fab,
    input  logic [1:0]        cfg_intf,
    input  logic              us_tick,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [TBL_AW-1:0] tbl_addr,
    input  logic [55:0]       tbl_data,
    output logic              bus_req,
    output logic              bus_we,
    output logic [3:0]        bus_space,
    output logic [15:0]       bus_addr,
    output logic [7:0]        bus_wdata,
    input  logic [7:0]        bus_rdata,
    input  logic              bus_ack,
    output logic              rd_valid,
    output logic [7:0]        rd_data
);
    localparam int PCW = $clog2(POLL_LIMIT + 1);

    state_e            state_q;
    logic [TBL_AW-1:0] ptr_q;
    entry_t            ent_q;
    entry_t            ent_in;
    logic [7:0]        wdata_q;
    logic [PCW-1:0]    poll_cnt_q;
    logic              done_q, err_q, rdv_q;
    logic [7:0]        rdd_q;
    logic              applies;
    logic              dly_load;
    logic              dly_expired;

    assign ent_in = entry_t'(tbl_data);

    pwrseq_gate u_gate (
        .ent      (ent_in),
        .cfg_cut  (cfg_cut),
        .cfg_fab  (cfg_fab),
        .cfg_intf (cfg_intf),
        .applies  (applies)
    );

    assign dly_load = (state_q == ST_FETCH) && applies && (ent_in.cmd == CMD_DELAY);

    pwrseq_timer #(.MS_TICKS(MS_TICKS), .AMT_W(16)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (dly_load),
        .amount  (ent_in.offset),
        .unit_ms (ent_in.val[0]),
        .tick    (us_tick),
        .expired (dly_expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            ptr_q      <= '0;
            ent_q      <= '0;
            wdata_q    <= '0;
            poll_cnt_q <= '0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            rdv_q      <= 1'b0;
            rdd_q      <= '0;
        end else begin
            rdv_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        ptr_q   <= '0;
                        done_q  <= 1'b0;
                        err_q   <= 1'b0;
                        state_q <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    ent_q      <= ent_in;
                    poll_cnt_q <= '0;
                    if (!applies) begin
                        ptr_q <= ptr_q + 1'b1;
                    end else begin
                        case (ent_in.cmd)
                            CMD_READ, CMD_WRITE, CMD_POLL: state_q <= ST_RD;
                            CMD_DELAY: state_q <= ST_WAIT;
                            CMD_END: begin
                                done_q  <= 1'b1;
                                state_q <= ST_IDLE;
                            end
                            default: begin
                                err_q   <= 1'b1;
                                state_q <= ST_IDLE;
                            end
                        endcase
                    end
                end
                ST_RD: begin
                    if (bus_ack) begin
                        case (ent_q.cmd)
                            CMD_WRITE: begin
                                wdata_q <= merge_bits(bus_rdata, ent_q.bmask, ent_q.val);
                                state_q <= ST_WR;
                            end
                            CMD_POLL: begin
                                if (masked_eq(bus_rdata, ent_q.val, ent_q.bmask)) begin
                                    ptr_q   <= ptr_q + 1'b1;
                                    state_q <= ST_FETCH;
                                end else if (poll_cnt_q == PCW'(POLL_LIMIT - 1)) begin
                                    err_q   <= 1'b1;
                                    state_q <= ST_IDLE;
                                end else begin
                                    poll_cnt_q <= poll_cnt_q + 1'b1;
                                end
                            end
                            default: begin
                                rdd_q   <= bus_rdata & ent_q.bmask;
                                rdv_q   <= 1'b1;
                                ptr_q   <= ptr_q + 1'b1;
                                state_q <= ST_FETCH;
                            end
                        endcase
                    end
                end
                ST_WR: begin
                    if (bus_ack) begin
                        ptr_q   <= ptr_q + 1'b1;
                        state_q <= ST_FETCH;
                    end
                end
                ST_WAIT: begin
                    if (dly_expired) begin
                        ptr_q   <= ptr_q + 1'b1;
                        state_q <= ST_FETCH;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign done      = done_q;
    assign error     = err_q;
    assign tbl_addr  = ptr_q;
    assign bus_req   = (state_q == ST_RD) || (state_q == ST_WR);
    assign bus_we    = (state_q == ST_WR);
    assign bus_space = ent_q.space;
    assign bus_addr  = ent_q.offset;
    assign bus_wdata = wdata_q;
    assign rd_valid  = rdv_q;
    assign rd_data   = rdd_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_addr)
                                && $stable(bus_space) && $stable(bus_wdata)); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bus_req && !rd_valid); // R9

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && !error); // R7

    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (rst)
        poll_cnt_q < PCW'(POLL_LIMIT)); // R5

    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy && start |=> $stable(ptr_q) || ptr_q == $past(ptr_q) + 1'b1); // R9

endmodule

// File: tb/tb_pwrseq_engine.sv
module tb_pwrseq_engine;
    import pwrseq_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  cfg_cut = 3'd1;
    logic [1:0]  cfg_fab = 2'd0;
    logic [1:0]  cfg_intf = 2'd1;
    logic        us_tick = 1'b0;
    logic        busy, done, error;
    logic [7:0]  tbl_addr;
    logic [55:0] tbl_data;
    logic        bus_req, bus_we, bus_ack;
    logic [3:0]  bus_space;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata, bus_rdata;
    logic        rd_valid;
    logic [7:0]  rd_data;

    logic [55:0] tbl [256];
    logic [7:0]  regs [4][256];
    logic [7:0]  poll_val = 8'h00;

    int checks = 0;
    int fails = 0;
    int ack_cnt = 0;
    int tick_total = 0;
    int rdv_ticks = 0;

    logic [27:0] wr_q[$];
    logic [7:0]  rd_q[$];

    always #4 clk = ~clk;

    assign tbl_data = tbl[tbl_addr];

    pwrseq_engine dut (
        .clk(clk), .rst(rst), .start(start), .cfg_cut(cfg_cut), .cfg_fab(cfg_fab),
        .cfg_intf(cfg_intf), .us_tick(us_tick), .busy(busy), .done(done), .error(error),
        .tbl_addr(tbl_addr), .tbl_data(tbl_data), .bus_req(bus_req), .bus_we(bus_we),
        .bus_space(bus_space), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // register bus slave model
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_ack   <= 1'b0;
            bus_rdata <= 8'h00;
            for (int s = 0; s < 4; s++)
                for (int a = 0; a < 256; a++) regs[s][a] <= 8'h00;
            regs[1][8'h10] <= 8'h3C;
            regs[2][8'h20] <= 8'h7E;
            regs[3][8'h31] <= 8'h5A;
        end else begin
            bus_ack <= bus_req && !bus_ack;
            if (bus_req && !bus_ack) begin
                if (bus_we) regs[bus_space[1:0]][bus_addr[7:0]] <= bus_wdata;
                bus_rdata <= (bus_space == 4'd3 && bus_addr == 16'h0030)
                             ? poll_val : regs[bus_space[1:0]][bus_addr[7:0]];
            end
        end
    end

    // microsecond tick: one pulse every fourth cycle
    initial begin
        forever begin
            repeat (3) @(posedge clk);
            #2 us_tick = 1'b1;
            tick_total++;
            @(posedge clk);
            #2 us_tick = 1'b0;
        end
    end

    task automatic check(input string req, input logic ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (bus_req && bus_ack) begin
                ack_cnt++;
                if (bus_we) begin
                    if (wr_q.size() == 0) check("R1", 1'b0, int'({bus_space, bus_addr, bus_wdata}), 0);
                    else begin
                        logic [27:0] e;
                        e = wr_q.pop_front();
                        check("R3", {bus_space, bus_addr, bus_wdata} == e,
                              int'({bus_space, bus_addr, bus_wdata}), int'(e));
                    end
                end
            end
            if (rd_valid) begin
                rdv_ticks = tick_total;
                if (rd_q.size() == 0) check("R2", 1'b0, int'(rd_data), 0);
                else begin
                    logic [7:0] e;
                    e = rd_q.pop_front();
                    check("R2", rd_data == e, int'(rd_data), int'(e));
                end
            end
        end
    end

    function automatic logic [55:0] mk(input logic [15:0] off, input logic [7:0] rv,
        input logic [3:0] fb, input logic [3:0] it, input logic [3:0] sp,
        input logic [3:0] cm, input logic [7:0] m, input logic [7:0] v);
        return {off, rv, fb, it, sp, cm, m, v};
    endfunction

    task automatic clear_tbl();
        for (int i = 0; i < 256; i++) tbl[i] = mk(16'h0, 8'hFF, 4'hF, 4'hF, 4'h0, CMD_END, 8'h0, 8'h0);
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 60000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int a0, t0;
        clear_tbl();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check("R9", !busy && !done && !error && !bus_req && !rd_valid,
              int'({busy, done, error, bus_req}), 0);

        // Sequence A: write, gated entries, reads
        tbl[0] = mk(16'h0010, 8'hFF, 4'hF, 4'hF, 4'd1, CMD_WRITE, 8'h0F, 8'hA5);
        tbl[1] = mk(16'h0040, 8'h01, 4'hF, 4'hF, 4'd0, CMD_WRITE, 8'hFF, 8'h11); // R1 revision miss
        tbl[2] = mk(16'h0041, 8'hFF, 4'hF, 4'h1, 4'd0, CMD_WRITE, 8'hFF, 8'h22); // R1 interface miss
        tbl[3] = mk(16'h0042, 8'hFF, 4'h2, 4'hF, 4'd0, CMD_READ,  8'hFF, 8'h33); // R1 fab miss
        tbl[4] = mk(16'h0020, 8'hFF, 4'hF, 4'hF, 4'd2, CMD_READ,  8'hF0, 8'hCC);
        tbl[5] = mk(16'h0010, 8'hFF, 4'hF, 4'hF, 4'd1, CMD_READ,  8'hFF, 8'h00);
        tbl[6] = mk(16'h0000, 8'hFF, 4'hF, 4'hF, 4'd0, CMD_END,   8'h00, 8'h00);
        wr_q.push_back({4'd1, 16'h0010, 8'h35});
        rd_q.push_back(8'h70);
        rd_q.push_back(8'h35);
        a0 = ack_cnt;
        pulse_start();
        check("R9", busy, int'(busy), 1);
        wait_idle();
        @(negedge clk);
        check("R7", done && !error && !busy, int'({done, error, busy}), 3'b100);
        check("R1", ack_cnt - a0 == 4, ack_cnt - a0, 4);
        check("R3", wr_q.size() == 0, wr_q.size(), 0);
        check("R2", rd_q.size() == 0, rd_q.size(), 0);

        // Sequence B: read, 40 us delay, start pulse ignored during the wait
        clear_tbl();
        tbl[0] = mk(16'h0031, 8'hFF, 4'hF, 4'hF, 4'd3, CMD_READ,  8'h3C, 8'hFF);
        tbl[1] = mk(16'd40,   8'hFF, 4'hF, 4'hF, 4'd0, CMD_DELAY, 8'h00, 8'h00);
        rd_q.push_back(8'h18);
        a0 = ack_cnt;
        pulse_start();
        repeat (60) @(negedge clk);
        pulse_start();
        check("R9", busy && !done, int'({busy, done}), 2'b10);
        wait_idle();
        t0 = tick_total - rdv_ticks;
        check("R6", t0 >= 40 && t0 <= 41, t0, 40);
        check("R9", ack_cnt - a0 == 1 && done, ack_cnt - a0, 1);

        // Sequence C: 2 ms delay
        clear_tbl();
        tbl[0] = mk(16'd2, 8'hFF, 4'hF, 4'hF, 4'd0, CMD_DELAY, 8'h00, 8'h01);
        pulse_start();
        t0 = tick_total;
        wait_idle();
        t0 = tick_total - t0;
        check("R6", t0 >= 2000 && t0 <= 2001, t0, 2000);
        check("R7", done && !error, int'({done, error}), 2'b10);

        // Sequence D: poll that matches after a while, then a read
        clear_tbl();
        tbl[0] = mk(16'h0030, 8'hFF, 4'hF, 4'hF, 4'd3, CMD_POLL, 8'h81, 8'h81);
        tbl[1] = mk(16'h0010, 8'hFF, 4'hF, 4'hF, 4'd1, CMD_READ, 8'hFF, 8'h00);
        poll_val = 8'h00;
        a0 = ack_cnt;
        pulse_start();
        repeat (100) @(negedge clk);
        check("R4", busy && rd_q.size() == 0, int'(busy), 1);
        rd_q.push_back(8'h35);
        poll_val = 8'h83;
        wait_idle();
        check("R4", done && !error && (ack_cnt - a0) > 10, ack_cnt - a0, 11);
        check("R4", rd_q.size() == 0, rd_q.size(), 0);

        // Sequence E: undefined opcode
        clear_tbl();
        tbl[0] = mk(16'h0010, 8'hFF, 4'hF, 4'hF, 4'd1, 4'd7, 8'hFF, 8'h00);
        a0 = ack_cnt;
        pulse_start();
        wait_idle();
        check("R8", error && !done && !busy, int'({error, done, busy}), 3'b100);
        check("R8", ack_cnt == a0, ack_cnt - a0, 0);

        // Sequence F: poll timeout after exactly the limit of reads
        clear_tbl();
        tbl[0] = mk(16'h0030, 8'hFF, 4'hF, 4'hF, 4'd3, CMD_POLL, 8'hFF, 8'h55);
        tbl[1] = mk(16'h0010, 8'hFF, 4'hF, 4'hF, 4'd1, CMD_READ, 8'hFF, 8'h00);
        poll_val = 8'h00;
        a0 = ack_cnt;
        pulse_start();
        wait_idle();
        repeat (4) @(negedge clk);
        check("R5", error && !done && !busy, int'({error, done, busy}), 3'b100);
        check("R5", ack_cnt - a0 == 20000, ack_cnt - a0, 20000);

        // Restart after error clears the flags
        clear_tbl();
        pulse_start();
        wait_idle();
        check("R9", done && !error, int'({done, error}), 2'b10);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule